// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Formatter

This block turns bytes written by a host into a serial bit stream at a fixed bit rate (1200 bit/s by default) for a downstream FSK modulator. The host writes a byte with a one-cycle strobe into a holding register. At the next bit boundary with the shifter free, the byte moves into a shift register. A ready output tells the host when the holding register can take another byte. Because holding and shifting are separate, a host that reloads within one character time gets a continuous stream with no gaps.

A single mode input picks the line format. With the mode low, each byte goes out as eight raw data bits, least significant first. With it high, each byte is wrapped as a character: a low start bit, the eight data bits and a high stop bit. The mode is sampled only when a byte enters the shifter, so a change never splits a character. A strobe pulses once per bit period, and the serial output changes only on the edge that follows it.

Top module: `sertx_top`

## Requirements
- R1: `bit_stb` is a single-cycle pulse that repeats every CLK_HZ/BIT_HZ clock cycles, and never on two consecutive cycles.
- R2: With `mode_async` = 0 when a byte is loaded, its 8 data bits go out in 8 consecutive bit periods, bit 0 first, with no start or stop bit.
- R3: With `mode_async` = 1 when a byte is loaded, the character is 10 bit periods: a 0 start bit, then data bits 0 to 7, then a 1 stop bit.
- R4: `tx_ready` is 1 after reset and reads 0 in the cycle after any `wr_stb`.
- R5: `tx_ready` returns to 1 on the clock edge right after a `bit_stb`, at which the held byte enters the shifter and its first bit appears on `tx_bit`.
- R6: A byte written while the previous character is still shifting follows it with no idle bit in between.
- R7: With nothing held and nothing shifting, `tx_bit` is 1, including right after reset.
- R8: A change of `mode_async` during a character does not alter that character; the next byte loaded uses the new mode.
- R9: `tx_bit` changes only on the clock edge that follows a cycle in which `bit_stb` is 1.
- R10: A second write before the held byte is taken replaces it; only the later byte is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_data | input | DATA_W | Byte to be transmitted |
| wr_stb | input | 1 | One-cycle write strobe for `wr_data` |
| mode_async | input | 1 | 0: raw synchronous bits; 1: start/stop framed characters |
| tx_ready | output | 1 | High while the holding register is empty |
| tx_bit | output | 1 | Serial data toward the modulator |
| bit_stb | output | 1 | Pulse marking each bit boundary |

## Verification
The bench builds the block with CLK_HZ = 12000 and BIT_HZ = 1200, so a bit lasts ten clocks instead of about a hundred thousand. This lets several full characters in both modes, back-to-back streams, a mode flip mid-character and an overwrite of the held byte all run in a few thousand cycles. The bit timing itself, checked at ten clocks, comes from the same division as the default.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [0:0] {
    FMT_SYNC  = 1'b0,
    FMT_ASYNC = 1'b1
  } fmt_e;

  localparam logic LINE_IDLE  = 1'b1;
  localparam logic START_LVL  = 1'b0;
  localparam logic STOP_LVL   = 1'b1;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = 1'b1;
  assign tick   = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (tick) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_stb,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_d;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  assign data_en = wr_stb;

  always_comb begin
    full_d = full;
    if (take)   full_d = 1'b0;
    if (wr_stb) full_d = 1'b1;
  end

  always_comb begin
    data_d = data;
    if (data_en) data_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              mode_async,
  output logic              take,
  output logic              line
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned RW      = $clog2(FRAME_W + 1);
  localparam logic [RW-1:0] SYNC_REST  = RW'(DATA_W - 1);
  localparam logic [RW-1:0] ASYNC_REST = RW'(DATA_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [RW-1:0]      rem_q, rem_d;
  logic               line_d;
  logic               busy;
  fmt_e               fmt;

  assign busy = (rem_q != '0);
  assign fmt  = fmt_e'(mode_async);
  assign take = tick && !busy && hold_full;

  always_comb begin
    sh_d   = sh_q;
    rem_d  = rem_q;
    line_d = line;
    if (tick) begin
      if (busy) begin
        line_d = sh_q[0];
        sh_d   = {1'b0, sh_q[FRAME_W-1:1]};
        rem_d  = rem_q - 1'b1;
      end else if (hold_full) begin
        if (fmt == FMT_ASYNC) begin
          line_d = START_LVL;
          sh_d   = {1'b0, STOP_LVL, hold_data};
          rem_d  = ASYNC_REST;
        end else begin
          line_d = hold_data[0];
          sh_d   = {2'b00, 1'b0, hold_data[DATA_W-1:1]};
          rem_d  = SYNC_REST;
        end
      end else begin
        line_d = LINE_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
      line  <= LINE_IDLE;
    end else begin
      sh_q  <= sh_d;
      rem_q <= rem_d;
      line  <= line_d;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned BIT_HZ = 1200,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_stb,
  input  logic              mode_async,
  output logic              tx_ready,
  output logic              tx_bit,
  output logic              bit_stb
);
  localparam int unsigned DIV = CLK_HZ / BIT_HZ;

  logic              tick;
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  sertx_baud #(.DIV(DIV)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_data(wr_data),
    .wr_stb (wr_stb),
    .take   (take),
    .full   (hold_full),
    .data   (hold_data)
  );

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .mode_async(mode_async),
    .take      (take),
    .line      (tx_bit)
  );

  assign tx_ready = !hold_full;
  assign bit_stb  = tick;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic mode_async,
  input logic tx_ready,
  input logic tx_bit,
  input logic bit_stb
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R1

  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !tx_ready); // R4

  AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(bit_stb)); // R5

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_ready) && $past(mode_async)) |-> !tx_bit); // R3

  AST_LINE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_stb) |-> $stable(tx_bit)); // R9
endmodule

bind sertx_top sertx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb    (wr_stb),
  .mode_async(mode_async),
  .tx_ready  (tx_ready),
  .tx_bit    (tx_bit),
  .bit_stb   (bit_stb)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  localparam int unsigned CLK_HZ = 12000;
  localparam int unsigned BIT_HZ = 1200;
  localparam int unsigned DIV    = CLK_HZ / BIT_HZ;

  logic       clk;
  logic       rst_n;
  logic [7:0] wr_data;
  logic       wr_stb;
  logic       mode_async;
  logic       tx_ready;
  logic       tx_bit;
  logic       bit_stb;

  int checks;
  int failures;
  bit done;

  // {mode, data}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h01},
    {1'b1, 8'h80}, {1'b1, 8'hFF}, {1'b0, 8'h00}
  };

  sertx_top #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_stb(wr_stb),
    .mode_async(mode_async), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .bit_stb(bit_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [9:0] frame(input logic m, input logic [7:0] d);
    if (m) return {1'b1, d, 1'b0};
    return {2'b00, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic next_bit(output logic b);
    @(negedge clk);
    while (!bit_stb) @(negedge clk);
    @(negedge clk);
    b = tx_bit;
  endtask

  task automatic grab(input int n, output logic [9:0] bits);
    logic b;
    bits = '0;
    for (int i = 0; i < n; i++) begin
      next_bit(b);
      bits[i] = b;
    end
  endtask

  initial begin
    logic [9:0] got;
    logic [9:0] got2;
    logic       b;
    int         gap;
    int         last;
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; wr_data = '0; wr_stb = 1'b0; mode_async = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 ready after reset", 32'(tx_ready), 32'd1);
    check("R7 idle after reset", 32'(tx_bit), 32'd1);
    rst_n = 1'b1;

    // R1: bit period
    @(negedge clk);
    while (!bit_stb) @(negedge clk);
    gap = 0;
    @(negedge clk);
    while (!bit_stb) begin gap++; @(negedge clk); end
    check("R1 bit period", 32'(gap + 1), 32'(DIV));

    // Table walk: R2, R3, R4, R7
    for (int v = 0; v < 6; v++) begin
      mode_async = VEC[v][8];
      wr(VEC[v][7:0]);
      check("R4 ready clears", 32'(tx_ready), 32'd0);
      grab(VEC[v][8] ? 10 : 8, got);
      check(VEC[v][8] ? "R3 async frame" : "R2 sync bits",
            32'(got), 32'(frame(VEC[v][8], VEC[v][7:0])));
      next_bit(b);
      check("R7 idle high", 32'(b), 32'd1);
    end

    // R5 + R6: back-to-back async
    mode_async = 1'b1;
    wr(8'h5A);
    next_bit(b);
    check("R5 ready on load", 32'(tx_ready), 32'd1);
    check("R3 start bit", 32'(b), 32'd0);
    wr(8'hC3);
    grab(9, got);
    grab(10, got2);
    check("R6 first char", 32'({got[8:0], b}), 32'(frame(1'b1, 8'h5A)));
    check("R6 second char no gap", 32'(got2), 32'(frame(1'b1, 8'hC3)));

    // R8: mode flip mid-character
    next_bit(b);
    mode_async = 1'b1;
    wr(8'h96);
    grab(3, got);
    mode_async = 1'b0;
    wr(8'h69);
    grab(7, got2);
    check("R8 char kept async", 32'({got2[6:0], got[2:0]}), 32'(frame(1'b1, 8'h96)));
    grab(8, got);
    check("R8 next byte sync", 32'(got), 32'(frame(1'b0, 8'h69)));

    // R10: overwrite of held byte
    next_bit(b);
    mode_async = 1'b1;
    wr(8'h11);
    next_bit(b);
    wr(8'h22);
    wr(8'h44);
    grab(9, got);
    grab(10, got2);
    check("R10 later write sent", 32'(got2), 32'(frame(1'b1, 8'h44)));

    // R9: line stable between strobes over a window
    last = 0;
    for (int c = 0; c < 4 * DIV; c++) begin
      b = tx_bit;
      @(negedge clk);
      if (!bit_stb && tx_bit !== b && last == 0) last = 1;
    end
    check("R9 line stable between boundaries", 32'(last), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule